// File: doc/BRIEF.md
# Coin-Operated Vend Controller

This block is the control state machine for a single-item vending machine that sells at 35 cents and takes nickels, dimes and quarters. A coin sensor presents a 2-bit code for exactly one clock per accepted coin. The controller keeps a running credit in 5-cent units.

When the credit reaches exactly 35 cents, the block raises a one-cycle vend pulse that releases the door. If a coin pushes the credit past the price, the block first pays the excess back, one nickel per clock. It counts down through the overpayment credits on an active-low change line. Then it vends and returns to zero credit. Coins offered while change is paid out or during the vend cycle have no effect.

All outputs are registered Moore outputs. The state can be held in a binary register or in a one-hot register, chosen by a parameter. The two variants behave the same at the ports. In the one-hot variant, a register holding no set bit or several set bits falls back to zero credit on the next clock. A debug output shows the current credit in 5-cent units.

Top module: `vend_ctrl`

## Requirements
- R1: Coin code 2'b01 adds one unit (5 cents), 2'b10 adds two units (10 cents), 2'b11 adds five units (25 cents), and 2'b00 adds nothing.
- R2: While the credit is below 35 cents, code 2'b00 leaves the credit unchanged.
- R3: From a credit below 35 cents, a coin moves the credit to the old credit plus the coin value on the next clock. A sum of exactly 35 cents (7 units) enters the vend state.
- R4: A sum above 35 cents enters an overpayment state equal to that sum (8 to 11 units, 40 to 55 cents). In those states nickel_n_o is 0 and vend_o is 0.
- R5: Each overpayment state steps down by one unit per clock whatever the coin input, and 8 units steps to the vend state.
- R6: The vend state shows vend_o=1 and nickel_n_o=1 for exactly one cycle, then goes to zero credit whatever the coin input.
- R7: A synchronous active-high rst gives credit 0, vend_o=0 and nickel_n_o=1 after the clock edge.
- R8: Every sale satisfies this balance: coins inserted equal 35 cents plus 5 cents for each cycle with nickel_n_o=0. In accumulation states nickel_n_o=1 and vend_o=0.
- R9: The binary and one-hot encodings give identical vend_o, nickel_n_o and credit_o for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_i | input | 2 | Coin code, valid for one clock per coin |
| vend_o | output | 1 | One-cycle door release pulse |
| nickel_n_o | output | 1 | Low for each clock in which one nickel is paid back |
| credit_o | output | CREDIT_W (4) | Current credit in 5-cent units (7 = vend state) |

## Verification
The assertions take the coin code to be a clean 2-bit value that returns to 00 between coins. Because of that, holding credit on a 00 code is the only idle behaviour they check. The stimulus presents each code for exactly one clock edge and then drives 00 again. During payout and vend cycles, the stimulus deliberately drives nonzero codes, to show that those codes are ignored there. A one-hot instance and a binary instance run side by side on the same inputs, and their outputs are compared on every step.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [1:0] {
    COIN_NONE    = 2'b00,
    COIN_NICKEL  = 2'b01,
    COIN_DIME    = 2'b10,
    COIN_QUARTER = 2'b11
  } coin_e;

  localparam int NICKEL_UNITS  = 1;
  localparam int DIME_UNITS    = 2;
  localparam int QUARTER_UNITS = 5;
endpackage

// File: rtl/vend_coin_value.sv
module vend_coin_value #(
  parameter int W = 4
) (
  input  logic [1:0]   coin_i,
  output logic [W-1:0] units_o
);
  import vend_pkg::*;

  always_comb begin
    unique case (coin_e'(coin_i))
      COIN_NICKEL:  units_o = W'(NICKEL_UNITS);
      COIN_DIME:    units_o = W'(DIME_UNITS);
      COIN_QUARTER: units_o = W'(QUARTER_UNITS);
      default:      units_o = '0;
    endcase
  end
endmodule

// File: rtl/vend_step.sv
module vend_step #(
  parameter int W     = 4,
  parameter int PRICE = 7
) (
  input  logic [W-1:0] cur_i,
  input  logic         legal_i,
  input  logic [W-1:0] add_i,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] PriceW = W'(PRICE);

  // accumulate below price, leave the vend state to zero, count payout down
  always_comb begin
    if (!legal_i)               nxt_o = '0;
    else if (cur_i < PriceW)    nxt_o = cur_i + add_i;
    else if (cur_i == PriceW)   nxt_o = '0;
    else                        nxt_o = cur_i - W'(1);
  end
endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg #(
  parameter bit ONE_HOT = 1'b0,
  parameter int W       = 4,
  parameter int NS      = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] nxt_i,
  output logic [W-1:0] cur_o,
  output logic         legal_o
);
  generate
    if (ONE_HOT) begin : g_onehot
      logic [NS-1:0] oh_q;

      always_ff @(posedge clk) begin
        if (rst) oh_q <= NS'(1);
        else     oh_q <= NS'(1) << nxt_i;
      end

      always_comb begin
        cur_o = '0;
        for (int i = 0; i < NS; i++)
          if (oh_q[i]) cur_o = cur_o | W'(i);
        legal_o = $onehot(oh_q);
      end

      // R9: the one-hot register never leaves the single-bit form
      a_r9_onehot_single: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $onehot(oh_q));
    end else begin : g_binary
      logic [W-1:0] bin_q;

      always_ff @(posedge clk) begin
        if (rst) bin_q <= '0;
        else     bin_q <= nxt_i;
      end

      assign cur_o   = bin_q;
      assign legal_o = (bin_q < W'(NS));
    end
  endgenerate
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
  parameter bit ONE_HOT       = 1'b0,
  parameter int PRICE_UNITS   = 7,
  parameter int QUARTER_UNITS = 5,
  localparam int MAX_UNITS    = PRICE_UNITS - 1 + QUARTER_UNITS,
  localparam int NUM_STATES   = MAX_UNITS + 1,
  localparam int CREDIT_W     = $clog2(NUM_STATES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          coin_i,
  output logic                vend_o,
  output logic                nickel_n_o,
  output logic [CREDIT_W-1:0] credit_o
);
  localparam logic [CREDIT_W-1:0] PriceW = CREDIT_W'(PRICE_UNITS);

  logic [CREDIT_W-1:0] add_units, cur_units, nxt_units;
  logic                cur_legal;

  vend_coin_value #(.W(CREDIT_W)) u_coin (
    .coin_i  (coin_i),
    .units_o (add_units)
  );

  vend_step #(.W(CREDIT_W), .PRICE(PRICE_UNITS)) u_step (
    .cur_i   (cur_units),
    .legal_i (cur_legal),
    .add_i   (add_units),
    .nxt_o   (nxt_units)
  );

  vend_state_reg #(.ONE_HOT(ONE_HOT), .W(CREDIT_W), .NS(NUM_STATES)) u_state (
    .clk     (clk),
    .rst     (rst),
    .nxt_i   (nxt_units),
    .cur_o   (cur_units),
    .legal_o (cur_legal)
  );

  // registered Moore outputs decoded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      vend_o     <= 1'b0;
      nickel_n_o <= 1'b1;
      credit_o   <= '0;
    end else begin
      vend_o     <= (nxt_units == PriceW);
      nickel_n_o <= !(nxt_units > PriceW);
      credit_o   <= nxt_units;
    end
  end

  // R2: no coin while accumulating keeps the credit
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (credit_o < PriceW && coin_i == 2'b00) |=> $stable(credit_o));

  // R5: payout counts down one unit per clock regardless of coin
  a_r5_payout_step: assert property (@(posedge clk) disable iff (rst)
    (credit_o > PriceW) |=> (credit_o == $past(credit_o) - CREDIT_W'(1)));

  // R6: vend lasts one cycle and is followed by zero credit
  a_r6_vend_once: assert property (@(posedge clk) disable iff (rst)
    vend_o |=> (!vend_o && credit_o == '0));

  // R4: change is never paid in the same cycle as the vend pulse
  a_r4_no_vend_change: assert property (@(posedge clk) disable iff (rst)
    !(vend_o && !nickel_n_o));

  // R8: change line is high whenever credit is still accumulating
  a_r8_accum_no_change: assert property (@(posedge clk) disable iff (rst)
    (credit_o < PriceW) |-> (nickel_n_o && !vend_o));
endmodule

// File: tb/tb_vend_ctrl.sv
`timescale 1ns/1ps
module tb_vend_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] coin = 2'b00;
  logic       vend_b, nick_b, vend_h, nick_h;
  logic [3:0] cred_b, cred_h;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vend_ctrl #(.ONE_HOT(1'b0)) dut (
    .clk(clk), .rst(rst), .coin_i(coin),
    .vend_o(vend_b), .nickel_n_o(nick_b), .credit_o(cred_b));

  vend_ctrl #(.ONE_HOT(1'b1)) dut_oh (
    .clk(clk), .rst(rst), .coin_i(coin),
    .vend_o(vend_h), .nickel_n_o(nick_h), .credit_o(cred_h));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R9: compare both encodings on every step
  task automatic same_enc();
    chk("R9 vend", int'(vend_h), int'(vend_b));
    chk("R9 nickel_n", int'(nick_h), int'(nick_b));
    chk("R9 credit", int'(cred_h), int'(cred_b));
  endtask

  task automatic step(input logic [1:0] c);
    coin = c;
    @(negedge clk);
    coin = 2'b00;
    same_enc();
  endtask

  function automatic int coin_units(input int c);
    case (c)
      1: return 1;
      2: return 2;
      3: return 5;
      default: return 0;
    endcase
  endfunction

  initial begin
    @(negedge clk);
    for (int s = 0; s < 7; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic [1:0] noise;
        int tot, k, nick;
        noise = 2'((s + c + 1) % 4);
        rst = 1'b1;
        step(2'b11);
        step(2'b00);
        rst = 1'b0;
        chk("R7 credit", int'(cred_b), 0);
        chk("R7 vend", int'(vend_b), 0);
        chk("R7 nickel_n", int'(nick_b), 1);
        for (int i = 0; i < s; i++) begin
          step(2'b01);
          chk("R1 nickel adds one", int'(cred_b), i + 1);
        end
        step(2'(c));
        tot = s + coin_units(c);
        chk(tot < 7 ? "R3 accumulate" : (tot == 7 ? "R3 exact price" : "R4 overpay"),
            int'(cred_b), tot);
        chk("R1 coin value vend", int'(vend_b), int'(tot == 7));
        chk("R4 nickel_n", int'(nick_b), int'(tot <= 7));
        if (tot < 7) begin
          step(2'b00);
          chk("R2 hold on 00", int'(cred_b), tot);
          chk("R8 no change while accumulating", int'(nick_b), 1);
        end else begin
          nick = 0;
          k = tot;
          while (k > 7) begin
            if (!nick_b) nick++;
            step(noise);
            k--;
            chk("R5 payout step", int'(cred_b), k);
          end
          chk("R6 vend high", int'(vend_b), 1);
          chk("R6 nickel_n high in vend", int'(nick_b), 1);
          step(noise);
          chk("R6 back to zero", int'(cred_b), 0);
          chk("R6 vend one cycle", int'(vend_b), 0);
          chk("R8 balance", 5 * tot, 35 + 5 * nick);
        end
      end
    end
    // R2: long idle after a dime keeps 10 cents
    rst = 1'b1; step(2'b00); rst = 1'b0;
    step(2'b10);
    for (int i = 0; i < 3; i++) begin
      step(2'b00);
      chk("R2 idle hold", int'(cred_b), 2);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule